// File: doc/BRIEF.md
# DMA Channel Interrupt Aggregator

This block gathers the interrupt conditions of a set of DMA channels into one global interrupt line. Each channel presents a five-bit status vector and a five-bit mask. A channel has a local condition whenever any status bit is set together with its mask bit. That condition sets the channel's bit in a global pending register. The pending bits are sticky, and software clears them by writing ones.

A global enable register selects which pending channels may drive the interrupt output. An idle register shows which channels are not running. Software reaches all three registers through a simple port, with a write strobe and a combinational read. Clearing a channel's own status is a separate step from clearing its global bit. While a channel's masked status stays non-zero, a write that clears its global bit does not take effect, so no event is lost.

Top module: `dma_irq_aggregator`

## Requirements
- R1: After a synchronous active-low reset, the pending register reads 0, the enable register reads 0, the idle register reads all ones for the channels, and `irq` is 0.
- R2: If any bit of a channel's status ANDed with its mask is 1 before a clock edge, that channel's pending bit is 1 after the edge. Channel i owns status and mask bits [5i+4:5i], and the pending, enable and idle registers all use bit i for channel i.
- R3: Status bits whose mask bit is 0 never set the pending bit.
- R4: Writing to offset 0x000 clears each pending bit whose write-data bit is 1 and leaves the others unchanged. Reading offset 0x000 returns the pending bits, zero-extended.
- R5: If a channel's masked status is non-zero in the same cycle as a write-one-to-clear of its pending bit, the set wins and the bit stays 1. The bit clears only after the masked status has dropped to zero.
- R6: A pending bit stays 1 after the channel's masked status returns to zero, until it is cleared by a write.
- R7: Offset 0x010 is a read/write enable register holding one bit per channel. Write-data bits at and above the channel count are dropped, and they read as 0.
- R8: `irq` is registered. It is 1 in the cycle after any channel has both its pending bit and its enable bit set, and 0 in the cycle after no such channel exists.
- R9: A pending channel whose enable bit is 0 stays visible in the pending register but does not raise `irq`.
- R10: Offset 0x02C reads bit i as 1 when `ch_busy[i]` was 0 at the previous clock edge. The register is read-only, and writes to it have no effect.
- R11: Reads from any other offset, including the per-channel bank region at 0x100 and above, return 0. Writes to those offsets change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ch_status | input | N_CH*ST_W | Interrupt status of each channel, 5 bits per channel |
| ch_mask | input | N_CH*ST_W | Interrupt mask of each channel, 5 bits per channel |
| ch_busy | input | N_CH | 1 while the channel is running |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Combinational read data for `reg_addr` |
| irq | output | 1 | Aggregated interrupt output |

## Verification
The hardest case to reach is a clear that arrives while the channel's masked status is still asserted. In that case the write must lose to the set, and the bit must fall only after the status is removed. The bench holds one channel's status high across a write-one-to-clear and reads the pending register back. It then drops the status, clears again, and reads once more. The one-cycle latency of `irq` is checked on both edges, including a disabled channel that is pending alongside an enabled one.

// File: rtl/dma_irq_pkg.sv
// Package: register offsets and select decode shared by the aggregator,
// its register read mux and its checker. Assumes 12-bit byte offsets.
package dma_irq_pkg;

    localparam int REG_AW = 12;

    localparam logic [REG_AW-1:0] OFF_PEND = 12'h000;
    localparam logic [REG_AW-1:0] OFF_EN   = 12'h010;
    localparam logic [REG_AW-1:0] OFF_IDLE = 12'h02C;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_PEND,
        SEL_EN,
        SEL_IDLE
    } reg_sel_e;

    // Map a byte offset to the register it selects.
    function automatic reg_sel_e reg_decode(input logic [REG_AW-1:0] a);
        reg_sel_e s;
        case (a)
            OFF_PEND: s = SEL_PEND;
            OFF_EN:   s = SEL_EN;
            OFF_IDLE: s = SEL_IDLE;
            default:  s = SEL_NONE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/irq_chan_cond.sv
// Module: irq_chan_cond
// Reduces each channel's status AND mask to a single local-condition bit.
// Assumes the status and mask buses pack channel i at bits [ST_W*i +: ST_W].
module irq_chan_cond #(
    parameter int N_CH = 4,
    parameter int ST_W = 5
) (
    input  logic [N_CH*ST_W-1:0] status,
    input  logic [N_CH*ST_W-1:0] mask,
    output logic [N_CH-1:0]      hit
);

    for (genvar i = 0; i < N_CH; i++) begin : g_ch
        logic [ST_W-1:0] masked;

        // Keep only the status bits that the channel's mask allows.
        always_comb masked = status[ST_W*i +: ST_W] & mask[ST_W*i +: ST_W];

        // The channel has a condition when any allowed bit is set.
        always_comb hit[i] = |masked;
    end

endmodule

// File: rtl/irq_pend_bank.sv
// Module: irq_pend_bank
// Holds the global pending, enable and idle registers and the registered
// interrupt output. A set from a channel condition overrides a clear in the
// same cycle. Assumes a synchronous active-low reset.
module irq_pend_bank #(
    parameter int N_CH = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_CH-1:0] hit,
    input  logic [N_CH-1:0] clr_mask,
    input  logic            en_we,
    input  logic [N_CH-1:0] en_wdata,
    input  logic [N_CH-1:0] busy,
    output logic [N_CH-1:0] pend_q,
    output logic [N_CH-1:0] en_q,
    output logic [N_CH-1:0] idle_q,
    output logic            irq_q
);

    logic [N_CH-1:0] pend_d;
    logic            irq_d;

    // Next pending value: drop the cleared bits, then apply the sets, so a set wins.
    always_comb pend_d = (pend_q & ~clr_mask) | hit;

    // Raw interrupt request: at least one channel is both pending and enabled.
    always_comb irq_d = |(pend_q & en_q);

    // Pending register with write-one-to-clear.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_d;
    end

    // Enable register, written whole when selected.
    always_ff @(posedge clk) begin
        if (!rst_n)     en_q <= '0;
        else if (en_we) en_q <= en_wdata;
    end

    // Idle bitmap: the inverse of busy, sampled every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) idle_q <= '1;
        else        idle_q <= ~busy;
    end

    // Registered interrupt output.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= irq_d;
    end

endmodule

// File: rtl/irq_reg_read.sv
// Module: irq_reg_read
// Combinational read mux for the global registers, zero-extending each one
// to the data width. Assumes N_CH <= DW.
module irq_reg_read
    import dma_irq_pkg::*;
#(
    parameter int N_CH = 4,
    parameter int DW   = 32
) (
    input  reg_sel_e        sel,
    input  logic [N_CH-1:0] pend,
    input  logic [N_CH-1:0] en,
    input  logic [N_CH-1:0] idle,
    output logic [DW-1:0]   rdata
);

    // Select the addressed register; unmapped offsets read zero.
    always_comb begin
        rdata = '0;
        case (sel)
            SEL_PEND: rdata[N_CH-1:0] = pend;
            SEL_EN:   rdata[N_CH-1:0] = en;
            SEL_IDLE: rdata[N_CH-1:0] = idle;
            default:  rdata = '0;
        endcase
    end

endmodule

// File: rtl/dma_irq_aggregator.sv
// Module: dma_irq_aggregator (top)
// Two-level interrupt collection for N_CH DMA channels: the masked channel
// status sets sticky global pending bits, which software clears by writing
// ones; the enabled pending bits drive a registered interrupt line.
// Assumes N_CH < DW and a single clock domain for channels and registers.
module dma_irq_aggregator
    import dma_irq_pkg::*;
#(
    parameter int N_CH = 4,
    parameter int ST_W = 5,
    parameter int DW   = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N_CH*ST_W-1:0] ch_status,
    input  logic [N_CH*ST_W-1:0] ch_mask,
    input  logic [N_CH-1:0]      ch_busy,
    input  logic                 reg_wr,
    input  logic [REG_AW-1:0]    reg_addr,
    input  logic [DW-1:0]        reg_wdata,
    output logic [DW-1:0]        reg_rdata,
    output logic                 irq
);

    reg_sel_e        sel;
    logic [N_CH-1:0] hit;
    logic [N_CH-1:0] clr_mask;
    logic            en_we;
    logic [N_CH-1:0] pend_q;
    logic [N_CH-1:0] en_q;
    logic [N_CH-1:0] idle_q;
    logic            unused_wdata;

    // Decode the register offset.
    always_comb sel = reg_decode(reg_addr);

    // Write-one-to-clear mask, active only for a write to the pending register.
    always_comb clr_mask = (reg_wr && sel == SEL_PEND) ? reg_wdata[N_CH-1:0] : '0;

    // Write strobe for the enable register.
    always_comb en_we = reg_wr && (sel == SEL_EN);

    // Upper write-data bits have no register behind them.
    always_comb unused_wdata = ^reg_wdata[DW-1:N_CH];

    irq_chan_cond #(.N_CH(N_CH), .ST_W(ST_W)) u_cond (
        .status (ch_status),
        .mask   (ch_mask),
        .hit    (hit)
    );

    irq_pend_bank #(.N_CH(N_CH)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .hit      (hit),
        .clr_mask (clr_mask),
        .en_we    (en_we),
        .en_wdata (reg_wdata[N_CH-1:0]),
        .busy     (ch_busy),
        .pend_q   (pend_q),
        .en_q     (en_q),
        .idle_q   (idle_q),
        .irq_q    (irq)
    );

    irq_reg_read #(.N_CH(N_CH), .DW(DW)) u_read (
        .sel   (sel),
        .pend  (pend_q),
        .en    (en_q),
        .idle  (idle_q),
        .rdata (reg_rdata)
    );

endmodule

// File: rtl/dma_irq_aggregator_chk.sv
// Module: dma_irq_aggregator_chk
// Property checker bound into dma_irq_aggregator. It relates the port
// stimulus to the global register state over time.
module dma_irq_aggregator_chk
    import dma_irq_pkg::*;
#(
    parameter int N_CH = 4,
    parameter int ST_W = 5,
    parameter int DW   = 32
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [N_CH*ST_W-1:0] ch_status,
    input logic [N_CH*ST_W-1:0] ch_mask,
    input logic                 reg_wr,
    input logic [REG_AW-1:0]    reg_addr,
    input logic [DW-1:0]        reg_wdata,
    input logic [N_CH-1:0]      pend,
    input logic [N_CH-1:0]      en,
    input logic                 irq
);

    logic [N_CH-1:0] set_vec;
    logic [N_CH-1:0] wr_clr;

    // Per-channel set request seen at the ports.
    always_comb begin
        for (int i = 0; i < N_CH; i++)
            set_vec[i] = |(ch_status[ST_W*i +: ST_W] & ch_mask[ST_W*i +: ST_W]);
    end

    // Bits targeted by a write-one-to-clear in this cycle.
    always_comb wr_clr = (reg_wr && reg_addr == OFF_PEND) ? reg_wdata[N_CH-1:0] : '0;

    // R2: a masked condition sets its pending bit by the next cycle.
    a_r2_set_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (set_vec != '0) |=> ((pend & $past(set_vec)) == $past(set_vec)));

    // R4: a cleared bit with no concurrent set reads 0 next cycle.
    a_r4_w1c: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_clr != '0) |=> ((pend & $past(wr_clr) & ~$past(set_vec)) == '0));

    // R6: pending bits never fall without a clear.
    a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(pend) & ~$past(wr_clr) & ~pend) == '0));

    // R7: enable holds unless written.
    a_r7_en_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_addr == OFF_EN) |=> $stable(en));

    // R8: an enabled pending channel raises irq next cycle.
    a_r8_irq_rise: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend & en) != '0) |=> irq);

    // R9: with no enabled pending channel, irq is low next cycle.
    a_r9_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend & en) == '0) |=> !irq);

endmodule

bind dma_irq_aggregator dma_irq_aggregator_chk #(
    .N_CH (N_CH),
    .ST_W (ST_W),
    .DW   (DW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ch_status (ch_status),
    .ch_mask   (ch_mask),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .pend      (pend_q),
    .en        (en_q),
    .irq       (irq)
);

// File: tb/dma_irq_aggregator_bench.sv
`timescale 1ns/1ps
module dma_irq_aggregator_bench;

    localparam int N_CH = 4;
    localparam int ST_W = 5;
    localparam int DW   = 32;
    localparam int SW   = N_CH*ST_W;
    localparam int NVEC = 7;

    // Vector table: status, mask, expected pending after one edge (R2, R3).
    localparam logic [SW-1:0] V_ST [NVEC] = '{20'h00001, 20'h003E0, 20'hFFFFF,
                                              20'h82082, 20'h82082, 20'hF8000, 20'h07C00};
    localparam logic [SW-1:0] V_MK [NVEC] = '{20'h0001F, 20'h00020, 20'h00000,
                                              20'h82082, 20'h7DF7D, 20'h40000, 20'h00400};
    localparam logic [N_CH-1:0] V_EXP [NVEC] = '{4'h1, 4'h2, 4'h0, 4'hF, 4'h0, 4'h8, 4'h4};

    localparam logic [11:0] A_PEND = 12'h000;
    localparam logic [11:0] A_EN   = 12'h010;
    localparam logic [11:0] A_IDLE = 12'h02C;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [SW-1:0]   ch_status = '0;
    logic [SW-1:0]   ch_mask = '0;
    logic [N_CH-1:0] ch_busy = '0;
    logic            reg_wr = 1'b0;
    logic [11:0]     reg_addr = '0;
    logic [DW-1:0]   reg_wdata = '0;
    logic [DW-1:0]   reg_rdata;
    logic            irq;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    dma_irq_aggregator #(.N_CH(N_CH), .ST_W(ST_W), .DW(DW)) u_dma_irq_aggregator (
        .clk(clk), .rst_n(rst_n), .ch_status(ch_status), .ch_mask(ch_mask),
        .ch_busy(ch_busy), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    task automatic check(input string req, input logic [DW-1:0] got, input logic [DW-1:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    task automatic rd(input logic [11:0] a, output logic [DW-1:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wr(input logic [11:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic drive(input logic [SW-1:0] st, input logic [SW-1:0] mk);
        @(negedge clk);
        ch_status = st; ch_mask = mk;
    endtask

    initial begin
        #4_000_000;
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] d;
        repeat (3) @(negedge clk);
        // R1: reset values
        rd(A_PEND, d); check("R1 pend", d, 0);
        rd(A_EN, d);   check("R1 en", d, 0);
        rd(A_IDLE, d); check("R1 idle", d, 32'hF);
        check("R1 irq", {31'b0, irq}, 0);
        rst_n = 1'b1;

        // R2/R3: vector walk, each followed by a full clear
        for (int v = 0; v < NVEC; v++) begin
            drive(V_ST[v], V_MK[v]);
            rd(A_PEND, d); check($sformatf("R2 R3 vec%0d", v), d, {28'b0, V_EXP[v]});
            drive('0, '0);
            wr(A_PEND, 32'hF);
            rd(A_PEND, d); check($sformatf("R4 vec%0d clear", v), d, 0);
        end

        // R6: sticky after status drops
        drive(20'h00020, 20'h00020);
        drive('0, '0);
        repeat (3) @(negedge clk);
        rd(A_PEND, d); check("R6 sticky", d, 32'h2);
        wr(A_PEND, 32'h2);

        // R4: partial clears
        drive(20'h00401, 20'h00401);
        drive('0, '0);
        wr(A_PEND, 32'h1);
        rd(A_PEND, d); check("R4 partial", d, 32'h4);
        wr(A_PEND, 32'h0);
        rd(A_PEND, d); check("R4 zero write", d, 32'h4);
        wr(A_PEND, 32'h4);
        rd(A_PEND, d); check("R4 last", d, 0);

        // R5: clear loses while masked status persists
        drive(20'h10000, 20'h10000);
        wr(A_PEND, 32'h8);
        rd(A_PEND, d); check("R5 set wins", d, 32'h8);
        drive('0, '0);
        wr(A_PEND, 32'h8);
        rd(A_PEND, d); check("R5 after drop", d, 0);

        // R7: enable register, upper bits dropped
        wr(A_EN, 32'hFFFF_FFF5);
        rd(A_EN, d); check("R7 en", d, 32'h5);

        // R9: disabled channel pending, no irq
        drive(20'h00020, 20'h00020);
        drive('0, '0);
        @(negedge clk);
        rd(A_PEND, d); check("R9 pend visible", d, 32'h2);
        check("R9 irq low", {31'b0, irq}, 0);

        // R8: enabled channel, one-cycle latency both ways
        drive(20'h00400, 20'h00400);
        @(negedge clk);                    // pend set at previous edge
        check("R8 irq latency", {31'b0, irq}, 0);
        ch_status = '0; ch_mask = '0;
        @(negedge clk);
        check("R8 irq high", {31'b0, irq}, 1);
        wr(A_PEND, 32'h4);
        check("R8 irq hold", {31'b0, irq}, 1);
        @(negedge clk);
        check("R8 irq fall", {31'b0, irq}, 0);
        wr(A_PEND, 32'h2);

        // R10: idle bitmap, read-only
        @(negedge clk); ch_busy = 4'b0101;
        rd(A_IDLE, d); check("R10 idle", d, 32'hA);
        wr(A_IDLE, 32'h0);
        rd(A_IDLE, d); check("R10 read-only", d, 32'hA);

        // R11: unmapped offsets
        rd(12'h100, d); check("R11 bank read", d, 0);
        rd(12'h004, d); check("R11 gap read", d, 0);
        wr(12'h014, 32'hF);
        rd(A_EN, d); check("R11 write ignored", d, 32'h5);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule